// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns one instruction operand into either an effective address or an operand value, chosen by a 4-bit mode code. On each start pulse it takes a register index, a signed displacement or constant field, a 26-bit jump field and the current program counter. It then returns a result one clock later, or several clocks later for the memory-indirect mode. An eight-entry register file sits inside the block. A load port fills it, and the auto-modify modes write the stepped pointer back into it.

Memory-indirect lookups go through a simple single-port read interface. The block raises a request with the pointer location and holds it until the memory answers with a read-valid. The word it gets back becomes the effective address. Every mode code outside the supported set is rejected with a one-cycle error pulse.

The controller has two states. In `S_IDLE` it accepts start. A start with the memory-indirect mode moves it to `S_FETCH`, while every other mode, and any unsupported code, leaves it in `S_IDLE`. In `S_FETCH` it waits for the read-valid and returns to `S_IDLE` when that arrives.

Top module: `eagen_top`

## Requirements
- R1: After reset these outputs are all low: `res_valid`, `ea_valid`, `opnd_valid`, `err` and `mem_req`. Every register file entry reads as zero.
- R2: Mode 0 (register) returns the contents of the named register on `opnd` with `opnd_valid` high and `ea_valid` low.
- R3: Mode 1 (absolute) returns `disp` on `ea` with `ea_valid` high. Mode 2 (immediate) returns `disp` on `opnd` with `opnd_valid` high and `ea_valid` low.
- R4: Mode 3 (register-indirect) returns the register contents as `ea`. Mode 5 (indexed) returns the register contents plus `disp`, so a register holding 1000 with a displacement of 20 gives 1020.
- R5: Mode 6 (PC-relative) returns `pc + disp` as `ea`.
- R6: Mode 7 (pseudodirect) returns `{pc[31:28], jfield, 2'b00}` as `ea`.
- R7: Mode 8 (auto-increment) returns the current register contents as `ea` and leaves the register incremented by STEP (default 4).
- R8: Mode 9 (auto-decrement) returns the current register contents as `ea` and leaves the register decremented by STEP.
- R9: Mode 4 (memory-indirect) raises `mem_req` with `mem_addr = disp` one cycle after start and holds it until `mem_rvalid` is sampled. In the following cycle `res_valid` and `ea_valid` are high and `ea` equals the returned `mem_rdata`.
- R10: A start pulse while a memory-indirect fetch is outstanding is ignored. It produces no result and does not modify any register.
- R11: Mode codes 10 to 15 produce a one-cycle `err` pulse one cycle after start, with `res_valid` low and no register changed.
- R12: Every mode except memory-indirect gives a `res_valid` pulse exactly one cycle after start, lasting one cycle when start is not repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one operand computation |
| mode | input | 4 | Addressing mode code |
| reg_idx | input | 3 | Register index |
| disp | input | 32 | Displacement, constant or address field |
| jfield | input | 26 | Jump target field |
| pc | input | 32 | Current program counter |
| ld_en | input | 1 | Register file load strobe |
| ld_idx | input | 3 | Register to load |
| ld_data | input | 32 | Load value |
| mem_req | output | 1 | Pointer read request, held until answered |
| mem_addr | output | 32 | Pointer location to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| res_valid | output | 1 | Result strobe |
| ea | output | 32 | Effective address |
| ea_valid | output | 1 | An address is produced |
| opnd | output | 32 | Operand value |
| opnd_valid | output | 1 | An operand value is produced |
| err | output | 1 | Unsupported mode pulse |

## Verification
The hardest situation to reach from the ports is a second start arriving while a memory-indirect fetch is still waiting. This start must be dropped, and it must also leave the register it names untouched. The bench creates this case on purpose. It delays the read-valid, injects an auto-increment start during the wait, and then reads that register back in register mode. The random stream adds memory latencies of zero to three cycles, which also covers a read-valid that arrives in the very first waiting cycle.

// File: rtl/eagen_pkg.sv
package eagen_pkg;
    typedef enum logic [3:0] {
        M_REG  = 4'd0,
        M_ABS  = 4'd1,
        M_IMM  = 4'd2,
        M_RIND = 4'd3,
        M_MIND = 4'd4,
        M_IDX  = 4'd5,
        M_REL  = 4'd6,
        M_PSD  = 4'd7,
        M_AINC = 4'd8,
        M_ADEC = 4'd9
    } amode_e;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_FETCH = 1'b1
    } state_e;
endpackage

// File: rtl/eagen_regfile.sv
module eagen_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 8,
    parameter int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  logic [DW-1:0] wb_data
);
    logic [DW-1:0] regs [NREG];

    // Pointer writeback takes priority over an external load to the same entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wb_en && wb_idx == IW'(i))
                regs[i] <= wb_data;
            else if (ld_en && ld_idx == IW'(i))
                regs[i] <= ld_data;
        end
    end

    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/eagen_calc.sv
module eagen_calc
    import eagen_pkg::*;
#(
    parameter int DW   = 32,
    parameter int JW   = 26,
    parameter int STEP = 4
) (
    input  logic [3:0]    mode,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] disp,
    input  logic [JW-1:0] jfield,
    input  logic [DW-1:0] pc,
    output logic [DW-1:0] ea,
    output logic          ea_ok,
    output logic [DW-1:0] opnd,
    output logic          opnd_ok,
    output logic          wb_en,
    output logic [DW-1:0] wb_data,
    output logic          indirect,
    output logic          bad
);
    localparam int PCW = DW - JW - 2;

    always_comb begin
        ea       = '0;
        ea_ok    = 1'b0;
        opnd     = '0;
        opnd_ok  = 1'b0;
        wb_en    = 1'b0;
        wb_data  = rdata;
        indirect = 1'b0;
        bad      = 1'b0;
        case (mode)
            M_REG:  begin opnd = rdata; opnd_ok = 1'b1; end
            M_ABS:  begin ea = disp; ea_ok = 1'b1; end
            M_IMM:  begin opnd = disp; opnd_ok = 1'b1; end
            M_RIND: begin ea = rdata; ea_ok = 1'b1; end
            M_MIND: indirect = 1'b1;
            M_IDX:  begin ea = rdata + disp; ea_ok = 1'b1; end
            M_REL:  begin ea = pc + disp; ea_ok = 1'b1; end
            M_PSD:  begin ea = {pc[DW-1 -: PCW], jfield, 2'b00}; ea_ok = 1'b1; end
            M_AINC: begin
                ea = rdata; ea_ok = 1'b1;
                wb_en = 1'b1; wb_data = rdata + DW'(STEP);
            end
            M_ADEC: begin
                ea = rdata; ea_ok = 1'b1;
                wb_en = 1'b1; wb_data = rdata - DW'(STEP);
            end
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/eagen_top.sv
module eagen_top
    import eagen_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NREG = 8,
    parameter int JW   = 26,
    parameter int STEP = 4,
    parameter int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [IW-1:0] reg_idx,
    input  logic [DW-1:0] disp,
    input  logic [JW-1:0] jfield,
    input  logic [DW-1:0] pc,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          res_valid,
    output logic [DW-1:0] ea,
    output logic          ea_valid,
    output logic [DW-1:0] opnd,
    output logic          opnd_valid,
    output logic          err
);
    state_e        state, nxt;
    logic [DW-1:0] r_data, c_ea, c_opnd, c_wb_data;
    logic          c_ea_ok, c_opnd_ok, c_wb_en, c_ind, c_bad;
    logic          accept;

    assign accept = (state == S_IDLE) && start;

    eagen_regfile #(.DW(DW), .NREG(NREG), .IW(IW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (reg_idx),
        .rd_data (r_data),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .wb_en   (accept && c_wb_en),
        .wb_idx  (reg_idx),
        .wb_data (c_wb_data)
    );

    eagen_calc #(.DW(DW), .JW(JW), .STEP(STEP)) u_calc (
        .mode     (mode),
        .rdata    (r_data),
        .disp     (disp),
        .jfield   (jfield),
        .pc       (pc),
        .ea       (c_ea),
        .ea_ok    (c_ea_ok),
        .opnd     (c_opnd),
        .opnd_ok  (c_opnd_ok),
        .wb_en    (c_wb_en),
        .wb_data  (c_wb_data),
        .indirect (c_ind),
        .bad      (c_bad)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start && c_ind) nxt = S_FETCH;
            S_FETCH: if (mem_rvalid)     nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req    <= 1'b0;
            mem_addr   <= '0;
            res_valid  <= 1'b0;
            ea         <= '0;
            ea_valid   <= 1'b0;
            opnd       <= '0;
            opnd_valid <= 1'b0;
            err        <= 1'b0;
        end else begin
            res_valid  <= 1'b0;
            ea_valid   <= 1'b0;
            opnd_valid <= 1'b0;
            err        <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    if (c_bad) begin
                        err <= 1'b1;
                    end else if (c_ind) begin
                        mem_req  <= 1'b1;
                        mem_addr <= disp;
                    end else begin
                        res_valid  <= 1'b1;
                        ea         <= c_ea;
                        ea_valid   <= c_ea_ok;
                        opnd       <= c_opnd;
                        opnd_valid <= c_opnd_ok;
                    end
                end
                S_FETCH: if (mem_rvalid) begin
                    mem_req   <= 1'b0;
                    res_valid <= 1'b1;
                    ea        <= mem_rdata;
                    ea_valid  <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/eagen_check.sv
module eagen_check
    import eagen_pkg::*;
#(
    parameter int DW = 32,
    parameter int JW = 26
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [3:0]    mode,
    input logic [DW-1:0] disp,
    input logic [JW-1:0] jfield,
    input logic [DW-1:0] pc,
    input logic          mem_req,
    input logic          mem_rvalid,
    input logic [DW-1:0] mem_rdata,
    input logic          res_valid,
    input logic [DW-1:0] ea,
    input logic          ea_valid,
    input logic          opnd_valid,
    input logic          err
);
    localparam int PCW = DW - JW - 2;

    a_r11_err_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !res_valid);

    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> mem_req);

    a_r9_rdata_to_ea: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> (res_valid && ea_valid && ea == $past(mem_rdata)));

    a_r2_qualifiers: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid || opnd_valid) |-> (res_valid && !(ea_valid && opnd_valid)));

    a_r5_relative: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && mode == M_REL) |=> (ea == $past(pc) + $past(disp)));

    a_r6_pseudodirect: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && mode == M_PSD) |=>
            (ea == {$past(pc[DW-1 -: PCW]), $past(jfield), 2'b00}));

    a_r10_busy_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> !res_valid);
endmodule

bind eagen_top eagen_check #(.DW(DW), .JW(JW)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .disp       (disp),
    .jfield     (jfield),
    .pc         (pc),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .res_valid  (res_valid),
    .ea         (ea),
    .ea_valid   (ea_valid),
    .opnd_valid (opnd_valid),
    .err        (err)
);

// File: tb/eagen_top_test.sv
module eagen_top_test;
    localparam int STEP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] disp = '0;
    logic [25:0] jfield = '0;
    logic [31:0] pc = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        res_valid;
    logic [31:0] ea;
    logic        ea_valid;
    logic [31:0] opnd;
    logic        opnd_valid;
    logic        err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] model [8];

    always #10 clk = ~clk;

    eagen_top uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_idx(reg_idx),
        .disp(disp), .jfield(jfield), .pc(pc), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_data(ld_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .res_valid(res_valid),
        .ea(ea), .ea_valid(ea_valid), .opnd(opnd), .opnd_valid(opnd_valid), .err(err)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(logic [3:0] m);
        case (m)
            4'd0: return "R2";
            4'd1, 4'd2: return "R3";
            4'd3, 4'd5: return "R4";
            4'd4: return "R9";
            4'd6: return "R5";
            4'd7: return "R6";
            4'd8: return "R7";
            4'd9: return "R8";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [31:0] exp_ea(logic [3:0] m, logic [31:0] r, logic [31:0] d,
                                           logic [25:0] j, logic [31:0] p);
        case (m)
            4'd1: return d;
            4'd3, 4'd8, 4'd9: return r;
            4'd5: return r + d;
            4'd6: return p + d;
            4'd7: return {p[31:28], j, 2'b00};
            default: return 32'h0;
        endcase
    endfunction

    task automatic load(logic [2:0] i, logic [31:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = i; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
        model[i] = v;
    endtask

    task automatic run_op(logic [3:0] m, logic [2:0] i, logic [31:0] d, logic [25:0] j,
                          logic [31:0] p, int lat, logic [31:0] md);
        string       rq;
        logic [31:0] rv;
        rq = req_of(m);
        rv = model[i];
        @(negedge clk);
        start = 1'b1; mode = m; reg_idx = i; disp = d; jfield = j; pc = p;
        @(negedge clk);
        start = 1'b0;
        if (m == 4'd4) begin
            chk("R9 req", {31'b0, mem_req}, 32'd1);
            chk("R9 addr", mem_addr, d);
            chk("R9 no early result", {31'b0, res_valid}, 32'd0);
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                chk("R9 req held", {31'b0, mem_req}, 32'd1);
            end
            mem_rvalid = 1'b1; mem_rdata = md;
            @(negedge clk);
            mem_rvalid = 1'b0;
            chk("R9 valid", {31'b0, res_valid & ea_valid}, 32'd1);
            chk("R9 ea", ea, md);
            chk("R9 req dropped", {31'b0, mem_req}, 32'd0);
        end else if (m > 4'd9) begin
            chk("R11 err", {31'b0, err}, 32'd1);
            chk("R11 no result", {31'b0, res_valid}, 32'd0);
        end else begin
            chk({rq, " R12 valid"}, {31'b0, res_valid}, 32'd1);
            if (m == 4'd0 || m == 4'd2) begin
                chk({rq, " opnd"}, opnd, (m == 4'd0) ? rv : d);
                chk({rq, " flags"}, {30'b0, ea_valid, opnd_valid}, 32'd1);
            end else begin
                chk({rq, " ea"}, ea, exp_ea(m, rv, d, j, p));
                chk({rq, " flags"}, {30'b0, ea_valid, opnd_valid}, 32'd2);
            end
            if (m == 4'd8) model[i] = rv + STEP;
            if (m == 4'd9) model[i] = rv - STEP;
            @(negedge clk);
            chk("R12 single pulse", {31'b0, res_valid}, 32'd0);
        end
    endtask

    task automatic read_reg(string rq, logic [2:0] i);
        @(negedge clk);
        start = 1'b1; mode = 4'd0; reg_idx = i;
        @(negedge clk);
        start = 1'b0;
        chk(rq, opnd, model[i]);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs", {27'b0, res_valid, ea_valid, opnd_valid, err, mem_req}, 32'd0);
        read_reg("R1 reg zero", 3'd3);

        load(3'd2, 32'd1000);
        run_op(4'd5, 3'd2, 32'd20, '0, '0, 0, '0);
        chk("R4 example", ea, 32'd1020);
        run_op(4'd3, 3'd2, 32'd7, '0, '0, 0, '0);
        run_op(4'd6, 3'd0, 32'hFFFF_FFF0, '0, 32'h0000_1000, 0, '0);
        run_op(4'd7, 3'd0, '0, 26'h3FF_FFFF, 32'hA123_4567, 0, '0);
        run_op(4'd1, 3'd0, 32'hDEAD_BEEF, '0, '0, 0, '0);
        run_op(4'd2, 3'd0, 32'h1234_5678, '0, '0, 0, '0);
        load(3'd5, 32'h100);
        run_op(4'd8, 3'd5, '0, '0, '0, 0, '0);
        read_reg("R7 incremented", 3'd5);
        run_op(4'd9, 3'd5, '0, '0, '0, 0, '0);
        run_op(4'd9, 3'd5, '0, '0, '0, 0, '0);
        read_reg("R8 decremented", 3'd5);
        run_op(4'd4, 3'd0, 32'h40, '0, '0, 0, 32'hCAFE_0000);
        run_op(4'd4, 3'd0, 32'h44, '0, '0, 3, 32'hCAFE_0004);
        run_op(4'd12, 3'd5, '0, '0, '0, 0, '0);
        read_reg("R11 regs unchanged", 3'd5);

        // R10: stray auto-increment start while the fetch waits
        load(3'd1, 32'h200);
        @(negedge clk);
        start = 1'b1; mode = 4'd4; disp = 32'h80;
        @(negedge clk);
        mode = 4'd8; reg_idx = 3'd1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 no result while busy", {31'b0, res_valid}, 32'd0);
        mem_rvalid = 1'b1; mem_rdata = 32'h5555_AAAA;
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk("R10 fetch result", ea, 32'h5555_AAAA);
        @(negedge clk);
        chk("R10 no extra result", {31'b0, res_valid}, 32'd0);
        read_reg("R10 register untouched", 3'd1);

        for (int n = 0; n < 400; n++) begin
            logic [3:0] m;
            logic [2:0] i;
            m = 4'($urandom_range(0, 15));
            i = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 5) == 0) load(i, $urandom);
            run_op(m, i, $urandom, 26'($urandom), $urandom, $urandom_range(0, 3), $urandom);
        end
        for (int i = 0; i < 8; i++) read_reg("R2 final regs", 3'(i));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule